// File: doc/BRIEF.md
# Horizontal Bayer Defect Pixel Corrector

A streaming corrector for single stuck or hot pixels on a raster of 10-bit Bayer samples. Each sample is compared with the nearest samples of its own colour on the same line, which sit two positions to the left and two to the right. If the sample is brighter than both of them, or darker than both of them, by more than a programmable threshold, it is replaced with the truncated mean of those two samples. Otherwise it leaves the block unchanged.

The block sits in the pixel path after capture. Samples arrive with a valid strobe and with flags that mark the first and last sample of a line. The corrected stream leaves with the same flags, delayed by a fixed two accepted samples. When the enable input is low, samples pass through untouched with the same delay. Samples near either end of a line lack one of their neighbours, so they are never altered.

Top module: `hbayer_dpc`

## Requirements
- R1: With en_i low, every output sample equals its input sample.
- R2: The comparison neighbours of sample k are samples k-2 and k+2 of the same line; samples k-1 and k+1 never take part.
- R3: Sample k is replaced only when it exceeds both neighbours by more than thr_i, or lies below both neighbours by more than thr_i; a difference exactly equal to thr_i, or an outlier toward only one neighbour, keeps the sample.
- R4: A replaced sample equals (left + right) >> 1, truncated, computed without overflow over the full 0..1023 range.
- R5: The first two and last two samples of a line (sol_i marks the first, eol_i the last; a line of one sample carries both) are never replaced.
- R6: The output for sample k appears, with valid_o high, in the cycle after sample k+2 is accepted; sol_o and eol_o carry the flags of sample k; valid_o is low in every other cycle.
- R7: During reset, and after it until two samples have been accepted, valid_o, sol_o and eol_o are low.
- R8: thr_i is an unsigned 7-bit threshold covering 0 to 127; the working setting is 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Correction enable; low means pass-through |
| thr_i | input | 7 | Outlier threshold, unsigned |
| valid_i | input | 1 | Input sample strobe |
| sol_i | input | 1 | Input sample is the first of its line |
| eol_i | input | 1 | Input sample is the last of its line |
| pix_i | input | 10 | Input sample value |
| valid_o | output | 1 | Output sample strobe |
| sol_o | output | 1 | Output sample is the first of its line |
| eol_o | output | 1 | Output sample is the last of its line |
| pix_o | output | 10 | Output sample value |

## Verification
On every cycle the assertions check that the output strobe only follows an accepted input, that the output flags match those of the sample two places back in the input stream, that pass-through holds when disabled and at line ends, and that any changed sample is a true outlier beyond the threshold whose new value is the mean of its two same-colour neighbours. What the properties cannot show is that outliers are actually caught: the scenarios must show that a spike one count past the threshold is replaced while one exactly at it is kept, that alternating colour planes never trigger, and that short lines and gapped streams stay aligned.

// File: rtl/hbdpc_pkg.sv
package hbdpc_pkg;
  typedef enum logic [1:0] {
    DEC_KEEP = 2'd0,
    DEC_HIGH = 2'd1,
    DEC_LOW  = 2'd2
  } dpc_dec_e;
endpackage

// File: rtl/hbdpc_stage.sv
module hbdpc_stage #(
  parameter int unsigned WIDTH = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (adv_i) q_o <= d_i;
  end
endmodule

// File: rtl/hbdpc_judge.sv
module hbdpc_judge
  import hbdpc_pkg::*;
#(
  parameter int unsigned PIX_W = 10,
  parameter int unsigned THR_W = 7
) (
  input  logic             en_i,
  input  logic             edge_i,
  input  logic [PIX_W-1:0] cen_i,
  input  logic [PIX_W-1:0] lft_i,
  input  logic [PIX_W-1:0] rgt_i,
  input  logic [THR_W-1:0] thr_i,
  output dpc_dec_e         dec_o,
  output logic [PIX_W-1:0] avg_o
);
  localparam int unsigned EXT_W = PIX_W + 1;

  logic [EXT_W-1:0] cen_x, lft_x, rgt_x, thr_x, sum_x;
  logic             above, below;

  assign cen_x = {1'b0, cen_i};
  assign lft_x = {1'b0, lft_i};
  assign rgt_x = {1'b0, rgt_i};
  assign thr_x = {{(EXT_W-THR_W){1'b0}}, thr_i};
  assign sum_x = lft_x + rgt_x;
  assign avg_o = sum_x[EXT_W-1:1];

  // strict compare: equal to threshold is not an outlier
  assign above = (cen_x > lft_x + thr_x) && (cen_x > rgt_x + thr_x);
  assign below = (cen_x + thr_x < lft_x) && (cen_x + thr_x < rgt_x);

  always_comb begin
    dec_o = DEC_KEEP;
    if (en_i && !edge_i) begin
      if (above)      dec_o = DEC_HIGH;
      else if (below) dec_o = DEC_LOW;
    end
  end
endmodule

// File: rtl/hbayer_dpc.sv
module hbayer_dpc
  import hbdpc_pkg::*;
#(
  parameter int unsigned PIX_W = 10,
  parameter int unsigned THR_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             valid_i,
  input  logic             sol_i,
  input  logic             eol_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             valid_o,
  output logic             sol_o,
  output logic             eol_o,
  output logic [PIX_W-1:0] pix_o
);
  localparam int unsigned REACH  = 2;            // same-colour spacing
  localparam int unsigned PIX_N  = 2 * REACH;    // pixel taps: k+1 .. k-2
  localparam int unsigned CTL_N  = REACH + 1;    // flag taps:  k+1 .. k-1
  localparam int unsigned CTL_W  = 3;
  localparam int unsigned B_V    = 2;
  localparam int unsigned B_S    = 1;
  localparam int unsigned B_E    = 0;

  logic [PIX_W-1:0] pix_tap [PIX_N+1];
  logic [CTL_W-1:0] ctl_tap [CTL_N+1];

  assign pix_tap[0] = pix_i;
  assign ctl_tap[0] = {1'b1, sol_i, eol_i};

  for (genvar g = 0; g < PIX_N; g++) begin : g_pix
    hbdpc_stage #(.WIDTH(PIX_W)) i_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .adv_i (valid_i),
      .d_i   (pix_tap[g]),
      .q_o   (pix_tap[g+1])
    );
  end

  for (genvar g = 0; g < CTL_N; g++) begin : g_ctl
    hbdpc_stage #(.WIDTH(CTL_W)) i_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .adv_i (valid_i),
      .d_i   (ctl_tap[g]),
      .q_o   (ctl_tap[g+1])
    );
  end

  logic [CTL_W-1:0] nxt, ctr, prv;
  logic             left_ok, right_ok;
  dpc_dec_e         dec;
  logic [PIX_W-1:0] avg, fixed;

  assign nxt = ctl_tap[REACH-1];
  assign ctr = ctl_tap[REACH];
  assign prv = ctl_tap[REACH+1];

  // a line break between k-2 and k, or between k and k+2, disables correction
  assign left_ok  = prv[B_V] & ~prv[B_S] & ~prv[B_E] & ~ctr[B_S];
  assign right_ok = ~ctr[B_E] & ~nxt[B_E];

  hbdpc_judge #(.PIX_W(PIX_W), .THR_W(THR_W)) i_judge (
    .en_i  (en_i),
    .edge_i(~(left_ok & right_ok)),
    .cen_i (pix_tap[REACH]),
    .lft_i (pix_tap[PIX_N]),
    .rgt_i (pix_i),
    .thr_i (thr_i),
    .dec_o (dec),
    .avg_o (avg)
  );

  assign fixed = (dec != DEC_KEEP) ? avg : pix_tap[REACH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sol_o   <= 1'b0;
      eol_o   <= 1'b0;
      pix_o   <= '0;
    end else begin
      valid_o <= valid_i & ctr[B_V];
      sol_o   <= valid_i & ctr[B_V] & ctr[B_S];
      eol_o   <= valid_i & ctr[B_V] & ctr[B_E];
      if (valid_i) pix_o <= fixed;
    end
  end
endmodule

// File: rtl/hbdpc_chk.sv
module hbdpc_chk #(
  parameter int unsigned PIX_W = 10,
  parameter int unsigned THR_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [THR_W-1:0] thr_i,
  input logic             valid_i,
  input logic             sol_i,
  input logic             eol_i,
  input logic [PIX_W-1:0] pix_i,
  input logic             valid_o,
  input logic             sol_o,
  input logic             eol_o,
  input logic [PIX_W-1:0] pix_o
);
  localparam int unsigned HIST = 5;
  localparam int unsigned EXT_W = PIX_W + 1;

  logic [PIX_W-1:0] hp [HIST];
  logic             hs [HIST];
  logic             he [HIST];
  logic             en_q;
  logic [THR_W-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < HIST; i++) begin
        hp[i] <= '0;
        hs[i] <= 1'b0;
        he[i] <= 1'b0;
      end
      en_q  <= 1'b0;
      thr_q <= '0;
    end else begin
      en_q  <= en_i;
      thr_q <= thr_i;
      if (valid_i) begin
        hp[0] <= pix_i;
        hs[0] <= sol_i;
        he[0] <= eol_i;
        for (int i = 1; i < HIST; i++) begin
          hp[i] <= hp[i-1];
          hs[i] <= hs[i-1];
          he[i] <= he[i-1];
        end
      end
    end
  end

  logic [EXT_W-1:0] c_x, l_x, r_x, t_x, m_x;
  logic             outlier;
  assign c_x = {1'b0, hp[2]};
  assign r_x = {1'b0, hp[0]};
  assign l_x = {1'b0, hp[4]};
  assign t_x = {{(EXT_W-THR_W){1'b0}}, thr_q};
  assign m_x = (l_x + r_x) >> 1;
  assign outlier = ((c_x > l_x + t_x) && (c_x > r_x + t_x)) ||
                   ((c_x + t_x < l_x) && (c_x + t_x < r_x));

  p_reset_quiet_r7: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !sol_o && !eol_o));

  p_valid_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));

  p_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (sol_o == hs[2] && eol_o == he[2]));

  p_bypass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !en_q) |-> pix_o == hp[2]);

  p_edge_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (hs[2] || hs[3] || he[2] || he[1])) |-> pix_o == hp[2]);

  // R2 and R4: a changed sample is the mean of samples k-2 and k+2
  p_mean_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && pix_o != hp[2]) |-> {1'b0, pix_o} == m_x);

  p_outlier_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && pix_o != hp[2]) |-> outlier);
endmodule

bind hbayer_dpc hbdpc_chk #(.PIX_W(PIX_W), .THR_W(THR_W)) i_chk (.*);

// File: tb/test_hbayer_dpc.sv
module test_hbayer_dpc;
  localparam int PIX_W = 10;
  localparam int THR_W = 7;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en_i = 1'b0, valid_i = 1'b0, sol_i = 1'b0, eol_i = 1'b0;
  logic [THR_W-1:0] thr_i = 7'd20;
  logic [PIX_W-1:0] pix_i = '0;
  logic valid_o, sol_o, eol_o;
  logic [PIX_W-1:0] pix_o;

  hbayer_dpc #(.PIX_W(PIX_W), .THR_W(THR_W)) i_hbayer_dpc (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .thr_i(thr_i),
    .valid_i(valid_i), .sol_i(sol_i), .eol_i(eol_i), .pix_i(pix_i),
    .valid_o(valid_o), .sol_o(sol_o), .eol_o(eol_o), .pix_o(pix_o));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  int lb [64];
  int acc [4096];
  int nin = 0, nout = 0;
  int q_pix [$];
  int q_flg [$];
  string q_tag [$];
  bit fin = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int model(int i, int len, bit en, int th, string ltag,
                               output string tag);
    int c, l, r;
    c = lb[i];
    if (i < 2 || i >= len - 2) begin tag = "R5"; return c; end
    if (!en) begin tag = "R1"; return c; end
    tag = ltag;
    l = lb[i-2];
    r = lb[i+2];
    if ((c > l + th && c > r + th) || (c + th < l && c + th < r))
      return (l + r) / 2;
    return c;
  endfunction

  task automatic flat(int len, int v);
    for (int i = 0; i < len; i++) lb[i] = v;
  endtask

  task automatic send_line(int len, bit en, int th, string ltag, int gap_pct,
                           bit expect_out);
    string t;
    int v;
    if (expect_out) begin
      for (int i = 0; i < len; i++) begin
        v = model(i, len, en, th, ltag, t);
        q_pix.push_back(v);
        q_flg.push_back({30'd0, i == 0, i == len - 1});
        q_tag.push_back(t);
      end
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      en_i    = en;
      thr_i   = THR_W'(th);
      valid_i = 1'b1;
      pix_i   = PIX_W'(lb[i]);
      sol_i   = (i == 0);
      eol_i   = (i == len - 1);
      acc[nin] = cyc + 1;
      nin++;
      if ($urandom_range(0, 99) < gap_pct) begin
        int g;
        g = $urandom_range(1, 3);
        repeat (g) begin
          @(negedge clk);
          valid_i = 1'b0;
        end
      end
    end
  endtask

  // output monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_ni && valid_o && !fin) begin
      if (q_pix.size() == 0) begin
        chk(1'b0, "R6", "unexpected valid_o", 1, 0);
      end else begin
        int ep, ef;
        string et;
        ep = q_pix.pop_front();
        ef = q_flg.pop_front();
        et = q_tag.pop_front();
        chk(int'(pix_o) == ep, et, "pix_o", int'(pix_o), ep);
        chk({sol_o, eol_o} == ef[1:0], "R6", "flags", {sol_o, eol_o}, ef);
        chk(cyc == acc[nout+2], "R6", "latency cycle", cyc, acc[nout+2]);
        nout++;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !fin) begin
      fin = 1'b1;
      failures++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd9137));
    repeat (3) @(negedge clk);
    chk(!valid_o && !sol_o && !eol_o, "R7", "outputs in reset",
        {valid_o, sol_o, eol_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(!valid_o && !sol_o && !eol_o, "R7", "outputs idle after reset",
        {valid_o, sol_o, eol_o}, 0);
    // R7: first accepted sample produces nothing yet
    flat(9, 100); lb[4] = 121;
    send_line(1, 1'b0, 20, "R1", 0, 1'b1);
    @(negedge clk); valid_i = 1'b0;
    chk(!valid_o, "R7", "no output after one sample", valid_o, 0);

    // R1: disabled, spike kept
    flat(9, 100); lb[4] = 121;
    send_line(9, 1'b0, 20, "R1", 0, 1'b1);
    // R3: exactly at threshold kept, one past replaced
    flat(9, 100); lb[4] = 120;
    send_line(9, 1'b1, 20, "R3", 0, 1'b1);
    flat(9, 100); lb[4] = 121;
    send_line(9, 1'b1, 20, "R3", 0, 1'b1);
    flat(9, 100); lb[4] = 80;
    send_line(9, 1'b1, 20, "R3", 0, 1'b1);
    flat(9, 100); lb[4] = 79;
    send_line(9, 1'b1, 20, "R3", 0, 1'b1);
    // R3: outlier toward one neighbour only
    flat(9, 100); lb[4] = 150; lb[6] = 200; lb[8] = 200;
    send_line(9, 1'b1, 20, "R3", 0, 1'b1);
    // R2: alternating colour planes never trigger at threshold 0
    for (int i = 0; i < 12; i++) lb[i] = (i % 2) ? 1000 : 0;
    send_line(12, 1'b1, 0, "R2", 0, 1'b1);
    // R4: odd sum truncates
    flat(9, 100); lb[4] = 500; lb[6] = 101;
    send_line(9, 1'b1, 20, "R4", 0, 1'b1);
    // R4: full-range extremes
    flat(9, 0); lb[4] = 1023;
    send_line(9, 1'b1, 127, "R4", 0, 1'b1);
    flat(9, 1023); lb[4] = 0;
    send_line(9, 1'b1, 127, "R4", 0, 1'b1);
    // R5: spikes at both line ends
    flat(10, 100); lb[0] = 900; lb[1] = 900; lb[8] = 900; lb[9] = 900;
    send_line(10, 1'b1, 0, "R5", 0, 1'b1);
    // R5: short lines
    lb[0] = 700; lb[1] = 5; lb[2] = 700; lb[3] = 5;
    send_line(1, 1'b1, 0, "R5", 0, 1'b1);
    send_line(2, 1'b1, 0, "R5", 0, 1'b1);
    send_line(4, 1'b1, 0, "R5", 0, 1'b1);
    // R8: threshold limits
    flat(9, 100); lb[4] = 227;
    send_line(9, 1'b1, 127, "R8", 0, 1'b1);
    flat(9, 100); lb[4] = 228;
    send_line(9, 1'b1, 127, "R8", 0, 1'b1);
    flat(9, 100); lb[4] = 101;
    send_line(9, 1'b1, 0, "R8", 0, 1'b1);
    // R6: gapped stream
    flat(12, 300); lb[5] = 900; lb[6] = 10;
    send_line(12, 1'b1, 20, "R6", 60, 1'b1);

    // random lines, R3
    for (int n = 0; n < 40; n++) begin
      int len, base, v;
      bit en;
      len  = $urandom_range(3, 48);
      base = $urandom_range(150, 850);
      for (int i = 0; i < len; i++) begin
        v = base + $urandom_range(0, 40) - 20;
        if ($urandom_range(0, 99) < 15) begin
          if ($urandom_range(0, 1)) v = v + $urandom_range(0, 300);
          else                      v = v - $urandom_range(0, 300);
        end
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
        lb[i] = v;
      end
      en = ($urandom_range(0, 99) < 80);
      send_line(len, en, $urandom_range(0, 127), "R3", 30, 1'b1);
    end

    // flush the last two samples out
    flat(2, 0);
    send_line(2, 1'b0, 20, "R6", 0, 1'b0);
    @(negedge clk); valid_i = 1'b0;
    repeat (10) @(negedge clk);
    chk(q_pix.size() == 0, "R6", "all samples delivered", q_pix.size(), 0);

    fin = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule